// File: doc/BRIEF.md
# Loadable Stepped Range Counter

This block is an up-counter that walks a value from a chosen start point to a chosen end point in fixed steps. A load strobe captures both the start and the end point in the same cycle. After that, each enabled cycle adds a programmable step to the count until the count equals the captured end point. The count then stays there until the next load. A done flag reports, in the same cycle, whether the present count equals the captured end point.

The block is meant as a timing primitive. A controller loads a range and raises enable. It then waits for done and loads again, for example to time the two halves of a square wave. Inputs that fall outside the supported range are undefined: a step that changes mid-count, a start above the end point, or a span that the step does not divide evenly. The block does not check for them.

Top module: `range_stepper`

## Requirements
- R1: A synchronous active-high reset sets the count to 0 and the captured end point to 0, so done reads 1 in the first cycle after reset.
- R2: When load is 1 at a rising edge, the count takes the start input and the captured end point takes the end input at that edge.
- R3: While load is 0, changes on the start and end inputs have no effect on the count or on done.
- R4: When enable is 1, load is 0 and done is 0, the count grows by the step input at each rising edge.
- R5: Once the count equals the captured end point, it holds that value while enable stays 1, and done stays 1.
- R6: When enable and load are both 0, the count keeps its value.
- R7: Done is 1 exactly when the registered count equals the captured end point. The count output shows the registered value, not the next one.
- R8: If the start and end inputs are equal at a load, done is 1 in the cycle right after the load.
- R9: Load takes priority over stepping and over saturation. With load and enable both 1, the next count is the start value, and counting proceeds from there.
- R10: Steps larger than 1 are supported, for example start 10, step 3 and end 19 give 10, 13, 16, 19, 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures the start and end inputs |
| step_en_i | input | 1 | Allows the count to advance |
| start_i | input | WIDTH | Value the count takes on load |
| finish_i | input | WIDTH | End point captured on load |
| incr_i | input | WIDTH | Amount added per enabled cycle |
| count_o | output | WIDTH | Present registered count |
| done_o | output | 1 | Count equals the captured end point |

## Verification
The hardest case to reach is showing that the end inputs are ignored while load is 0. Such a change only becomes visible when the count reaches the new value and would wrongly stop there. To reach it, the stimulus moves the end input to a value that the count is about to pass through. The start input is changed at the same time. Two further cases need ordered sequences: the reload that leaves a saturated count, and the load that interrupts a count in progress.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   // How the end-point comparison is built.
   typedef enum int {
      EQ_DIRECT    = 0,   // behavioural equality
      EQ_XNOR_TREE = 1    // per-bit match vector folded by an AND
   } eq_style_e;

endpackage

// File: rtl/rsc_state_reg.sv
// Holding register with synchronous reset and an X-aware reset path.
module rsc_state_reg #(
   parameter int             WIDTH   = 16,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("rsc_state_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if ($isunknown(rst)) q <= 'x;
      else if (rst)        q <= RST_VAL;
      else                 q <= d;
   end

endmodule

// File: rtl/rsc_eq_cmp.sv
// Equality of two words. A parameter selects how the comparison is built.
module rsc_eq_cmp #(
   parameter int                WIDTH = 16,
   parameter rsc_pkg::eq_style_e STYLE = rsc_pkg::EQ_XNOR_TREE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             eq
);

   if (STYLE == rsc_pkg::EQ_DIRECT) begin : g_direct
      assign eq = (a == b);
   end else begin : g_tree
      logic [WIDTH-1:0] bit_match;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign bit_match[i] = ~(a[i] ^ b[i]);
      end
      assign eq = &bit_match;
   end

endmodule

// File: rtl/rsc_next_logic.sv
// Next-state logic for the count and the captured end point.
module rsc_next_logic #(
   parameter int WIDTH = 16
) (
   input  logic             load,
   input  logic             step_en,
   input  logic             at_end,
   input  logic [WIDTH-1:0] start,
   input  logic [WIDTH-1:0] finish,
   input  logic [WIDTH-1:0] incr,
   input  logic [WIDTH-1:0] cnt_q,
   input  logic [WIDTH-1:0] fin_q,
   output logic [WIDTH-1:0] cnt_d,
   output logic [WIDTH-1:0] fin_d
);

   always_comb begin
      cnt_d = cnt_q;
      fin_d = fin_q;
      if ($isunknown(load)) begin
         cnt_d = 'x;
         fin_d = 'x;
      end else if (load) begin
         cnt_d = start;
         fin_d = finish;
      end else if ($isunknown(step_en)) begin
         cnt_d = 'x;
      end else if (step_en && !at_end) begin
         cnt_d = cnt_q + incr;
      end
   end

endmodule

// File: rtl/range_stepper.sv
module range_stepper #(
   parameter int                WIDTH    = 16,
   parameter rsc_pkg::eq_style_e EQ_STYLE = rsc_pkg::EQ_XNOR_TREE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             step_en_i,
   input  logic [WIDTH-1:0] start_i,
   input  logic [WIDTH-1:0] finish_i,
   input  logic [WIDTH-1:0] incr_i,
   output logic [WIDTH-1:0] count_o,
   output logic             done_o
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 2) begin : g_bad_width
      $error("range_stepper: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q, cnt_d;
   logic [WIDTH-1:0] fin_q, fin_d;
   logic             at_end;

   rsc_state_reg #(.WIDTH(WIDTH), .RST_VAL(ZERO)) u_cnt_reg (
      .clk(clk), .rst(rst), .d(cnt_d), .q(cnt_q)
   );

   rsc_state_reg #(.WIDTH(WIDTH), .RST_VAL(ZERO)) u_fin_reg (
      .clk(clk), .rst(rst), .d(fin_d), .q(fin_q)
   );

   rsc_eq_cmp #(.WIDTH(WIDTH), .STYLE(EQ_STYLE)) u_eq (
      .a(cnt_q), .b(fin_q), .eq(at_end)
   );

   rsc_next_logic #(.WIDTH(WIDTH)) u_next (
      .load(load_i), .step_en(step_en_i), .at_end(at_end),
      .start(start_i), .finish(finish_i), .incr(incr_i),
      .cnt_q(cnt_q), .fin_q(fin_q), .cnt_d(cnt_d), .fin_d(fin_d)
   );

   assign count_o = cnt_q;
   assign done_o  = at_end;

   AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (rst)
      load_i |=> count_o == $past(start_i));                        // R9

   AST_FINISH_CAPTURED: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (done_o == ($past(start_i) == $past(finish_i)))); // R8

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (!load_i && step_en_i && !done_o)
         |=> count_o == WIDTH'($past(count_o) + $past(incr_i)));   // R4

   AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load_i && done_o) |=> ($stable(count_o) && done_o));       // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !step_en_i) |=> $stable(count_o));               // R6

   AST_END_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(fin_q));                                  // R3

endmodule

// File: tb/range_stepper_test.sv
module range_stepper_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   typedef struct packed {
      logic         ld;
      logic         en;
      logic [W-1:0] st;
      logic [W-1:0] inc;
      logic [W-1:0] fin;
      logic [W-1:0] exp_cnt;
      logic         exp_done;
   } vec_t;

   localparam int NVEC = 13;
   // Each row: inputs for the cycle, then the outputs expected in that cycle.
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b1, 16'd5,   16'd2, 16'd11, 16'd0,  1'b1}, // R1 reset state, R9 load with enable
      '{1'b0, 1'b1, 16'd5,   16'd2, 16'd11, 16'd5,  1'b0}, // R2 start taken
      '{1'b0, 1'b0, 16'd5,   16'd2, 16'd11, 16'd7,  1'b0}, // R4 stepped by 2
      '{1'b0, 1'b0, 16'd5,   16'd2, 16'd11, 16'd7,  1'b0}, // R6 hold
      '{1'b0, 1'b1, 16'd5,   16'd2, 16'd11, 16'd7,  1'b0}, // R6 hold
      '{1'b0, 1'b1, 16'd5,   16'd2, 16'd11, 16'd9,  1'b0}, // R4
      '{1'b0, 1'b1, 16'd5,   16'd2, 16'd11, 16'd11, 1'b1}, // R7 done same cycle
      '{1'b0, 1'b1, 16'd5,   16'd2, 16'd11, 16'd11, 1'b1}, // R5 saturate
      '{1'b1, 1'b1, 16'd5,   16'd2, 16'd11, 16'd11, 1'b1}, // R5 before reload
      '{1'b0, 1'b1, 16'd100, 16'd2, 16'd9,  16'd5,  1'b0}, // R9 reload from end
      '{1'b0, 1'b1, 16'd100, 16'd2, 16'd9,  16'd7,  1'b0}, // R3
      '{1'b0, 1'b1, 16'd100, 16'd2, 16'd9,  16'd9,  1'b0}, // R3 not done at 9
      '{1'b0, 1'b1, 16'd100, 16'd2, 16'd9,  16'd11, 1'b1}  // R3 end point kept
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_i = 1'b0;
   logic         step_en_i = 1'b0;
   logic [W-1:0] start_i = '0;
   logic [W-1:0] finish_i = '0;
   logic [W-1:0] incr_i = '0;
   logic [W-1:0] count_o;
   logic         done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   range_stepper #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .load_i(load_i), .step_en_i(step_en_i),
      .start_i(start_i), .finish_i(finish_i), .incr_i(incr_i),
      .count_o(count_o), .done_o(done_o)
   );

   task automatic check(input string req, input logic [W-1:0] ec, input logic ed);
      checks++;
      if (count_o !== ec || done_o !== ed) begin
         errors++;
         $display("FAIL %s: count=%0d done=%0b expected count=%0d done=%0b",
                  req, count_o, done_o, ec, ed);
      end
   endtask

   // Drive inputs at a falling edge, then check outputs of that cycle.
   task automatic cyc(input logic ld, input logic en, input logic [W-1:0] s,
                      input logic [W-1:0] i, input logic [W-1:0] f,
                      input string req, input logic [W-1:0] ec, input logic ed);
      @(negedge clk);
      load_i = ld; step_en_i = en; start_i = s; incr_i = i; finish_i = f;
      check(req, ec, ed);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1", 16'd0, 1'b1);

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         load_i = VECS[k].ld; step_en_i = VECS[k].en;
         start_i = VECS[k].st; incr_i = VECS[k].inc; finish_i = VECS[k].fin;
         check($sformatf("vector %0d", k), VECS[k].exp_cnt, VECS[k].exp_done);
      end

      // R1: reset in the middle of operation
      @(negedge clk);
      rst = 1'b1; load_i = 1'b0; step_en_i = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 mid-run reset", 16'd0, 1'b1);

      // R8: equal start and end
      cyc(1'b1, 1'b1, 16'd20, 16'd1, 16'd20, "R8 pre-load", 16'd0, 1'b1);
      cyc(1'b0, 1'b1, 16'd20, 16'd1, 16'd20, "R8", 16'd20, 1'b1);
      cyc(1'b0, 1'b1, 16'd20, 16'd1, 16'd20, "R8 R5 hold", 16'd20, 1'b1);

      // R10: step of 3 from 10 to 19
      cyc(1'b1, 1'b1, 16'd10, 16'd3, 16'd19, "R10 pre-load", 16'd20, 1'b1);
      cyc(1'b0, 1'b1, 16'd10, 16'd3, 16'd19, "R10", 16'd10, 1'b0);
      cyc(1'b0, 1'b1, 16'd10, 16'd3, 16'd19, "R10", 16'd13, 1'b0);
      cyc(1'b0, 1'b1, 16'd10, 16'd3, 16'd19, "R10", 16'd16, 1'b0);
      cyc(1'b0, 1'b1, 16'd10, 16'd3, 16'd19, "R10", 16'd19, 1'b1);
      cyc(1'b0, 1'b1, 16'd10, 16'd3, 16'd19, "R10 R5", 16'd19, 1'b1);

      // R9: load interrupts a count in progress
      cyc(1'b1, 1'b1, 16'd40, 16'd3, 16'd49, "R9 pre-load", 16'd19, 1'b1);
      cyc(1'b0, 1'b1, 16'd40, 16'd3, 16'd49, "R9", 16'd40, 1'b0);
      cyc(1'b1, 1'b1, 16'd1,  16'd3, 16'd7,  "R9", 16'd43, 1'b0);
      cyc(1'b0, 1'b1, 16'd1,  16'd3, 16'd7,  "R9 restart", 16'd1, 1'b0);
      cyc(1'b0, 1'b0, 16'd1,  16'd3, 16'd7,  "R4", 16'd4, 1'b0);
      cyc(1'b0, 1'b1, 16'd1,  16'd3, 16'd7,  "R6", 16'd4, 1'b0);
      cyc(1'b0, 1'b0, 16'd1,  16'd3, 16'd7,  "R7", 16'd7, 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule